// File: doc/BRIEF.md
# Doorbell-Driven Descriptor Fetch Scheduler

This block sits between the notification path of a set of packed descriptor rings and the engine that pulls descriptors out of host memory. Software rings a doorbell naming a queue, the ring slot at which its next descriptor will be written, and the wrap phase of that slot. The block stores that as the queue's tail. It also keeps a head position for descriptors it has already asked for, so the number of descriptors ready on every queue is known from internal state alone. The block never probes ring memory to find out whether a slot is filled.

A round-robin scheduler picks one queue that has work and raises a single fetch request with a start slot and a length. The length is capped so that a request never runs past the end of the ring. A head moves only when its request is taken. Each queue has a ring size that software writes, and a per-queue clear input returns the queue's positions to their initial state. Doorbells that name a queue that does not exist, or a slot outside the ring, are thrown away and raise a sticky error flag.

Top module: `dbt_tail_tracker`

## Requirements
- R1: After reset `fq_valid` and `db_err` are 0, every available count on `avail_o` (16 bits per queue, queue q at bits 16q+15..16q) is 0, every ring size is `DEF_RING` (16), and every head and tail wrap bit is 1.
- R2: A doorbell accepted with a wrap bit equal to the head's wrap bit sets that queue's available count to offset minus head slot, visible the cycle after the doorbell.
- R3: When the stored tail wrap bit differs from the head wrap bit, the available count is tail slot plus ring size minus head slot.
- R4: A doorbell that repeats the stored offset and wrap bit leaves the available count unchanged.
- R5: A doorbell whose queue number is NUM_Q (4) or above, or whose offset is at or above that queue's ring size, changes no count. It sets `db_err`, which then stays 1 until reset.
- R6: A fetch request carries start slot equal to the queue's head slot and length equal to the smallest of the available count, MAX_BURST (8) and ring size minus head slot. Its length is therefore never 0 and never crosses the ring end.
- R7: While `fq_valid` is 1 and `fq_ready` is 0, the request stays raised with queue, start and length unchanged.
- R8: When a request is taken (`fq_valid` and `fq_ready` both 1 at a clock edge), that queue's head advances by the length. At the ring end the head becomes slot 0 and its wrap bit toggles. `fq_valid` is 0 in the next cycle.
- R9: Queues are served round robin. After a request for queue g, the search for the next request starts at queue g+1, wrapping to 0.
- R10: A doorbell and a taken request for the same queue in the same cycle are both applied. The count afterwards is the new tail less the advanced head.
- R11: A `q_clear` pulse on one queue sets its head and tail slots to 0 and both wrap bits to 1, so its count becomes 0. A later doorbell with wrap bit 1 and offset n gives a count of n.
- R12: `fq_valid` rises only when some queue has a nonzero available count.
- R13: A configuration write (`cfg_we` with an in-range `cfg_qid`) sets that queue's ring size, which then bounds doorbell offsets and request lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Ring size write strobe |
| cfg_qid | input | 16 | Queue addressed by the size write |
| cfg_size | input | 16 | New ring size in descriptors |
| q_clear | input | NUM_Q | Per-queue clear of head and tail state |
| db_valid | input | 1 | Doorbell strobe |
| db_qid | input | 16 | Doorbell queue number |
| db_off | input | 15 | Slot where the next descriptor will be written |
| db_wrap | input | 1 | Wrap phase of that slot |
| db_err | output | 1 | Sticky flag for dropped doorbells |
| avail_o | output | NUM_Q*16 | Available descriptor count of each queue |
| fq_valid | output | 1 | Fetch request raised |
| fq_ready | input | 1 | Fetch request taken |
| fq_qid | output | 16 | Queue of the request |
| fq_start | output | 15 | First ring slot to fetch |
| fq_len | output | LEN_W | Number of descriptors to fetch |

## Verification
A wrong head or tail shows on `avail_o` one cycle after the doorbell, configuration write or taken request that caused it. It also shows in the start slot and length of the next fetch request, which appears at the earliest two cycles later. A wrong wrap bit shows only once a ring wraps. The count then comes out off by the ring size, or a request starts at the wrong slot. For that reason the bench drives one queue past its ring end and pairs a doorbell with a taken request in the same cycle. A scoreboard orders the expected requests by the round-robin rule and compares every request that is taken.

// File: rtl/dbt_pkg.sv
// Package: shared widths and the ring position type.
// Assumes: offsets are whole descriptors and ring sizes fit in SIZE_W bits.
package dbt_pkg;
    localparam int QID_W  = 16;
    localparam int OFF_W  = 15;
    localparam int SIZE_W = OFF_W + 1;

    typedef struct packed {
        logic [OFF_W-1:0] slot;
        logic             wrap;
    } ring_pos_t;
endpackage

// File: rtl/dbt_queue_state.sv
// Module: one queue's ring size, tail and head positions and its available count.
// Assumes: head slot stays below ring size; size changes happen while the queue is idle.
module dbt_queue_state
    import dbt_pkg::*;
#(
    parameter int DEF_RING = 16,
    parameter int LEN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cfg_we,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              db_we,
    input  logic [OFF_W-1:0]  db_off,
    input  logic              db_wrap,
    input  logic              adv_we,
    input  logic [LEN_W-1:0]  adv_len,
    output logic [SIZE_W-1:0] size_o,
    output logic [OFF_W-1:0]  head_o,
    output logic [SIZE_W-1:0] avail_o
);
    localparam ring_pos_t POS_INIT = '{slot: '0, wrap: 1'b1};

    ring_pos_t         tail_r, head_r, head_nxt;
    logic [SIZE_W-1:0] size_r;
    logic [SIZE_W-1:0] adv_sum;

    // Head position after a taken request, folding to slot 0 at the ring end.
    always_comb begin
        adv_sum  = {1'b0, head_r.slot} + SIZE_W'(adv_len);
        head_nxt = head_r;
        if (adv_sum >= size_r) begin
            head_nxt.slot = '0;
            head_nxt.wrap = ~head_r.wrap;
        end else begin
            head_nxt.slot = adv_sum[OFF_W-1:0];
        end
    end

    // Ring size register, written by configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      size_r <= SIZE_W'(DEF_RING);
        else if (cfg_we) size_r <= cfg_size;
    end

    // Tail and head registers; clear wins over doorbell and advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tail_r <= POS_INIT;
            head_r <= POS_INIT;
        end else begin
            if (db_we)  tail_r <= '{slot: db_off, wrap: db_wrap};
            if (adv_we) head_r <= head_nxt;
        end
    end

    // Distance from head to tail, adding one ring when the phases differ.
    always_comb begin
        if (tail_r.wrap == head_r.wrap)
            avail_o = {1'b0, tail_r.slot} - {1'b0, head_r.slot};
        else
            avail_o = {1'b0, tail_r.slot} + size_r - {1'b0, head_r.slot};
    end

    assign size_o = size_r;
    assign head_o = head_r.slot;
endmodule

// File: rtl/dbt_rr_arb.sv
// Module: combinational round-robin pick among request bits.
// Assumes: ptr < N; the caller moves ptr past the winner after each grant.
module dbt_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] gnt,
    output logic          any
);
    // Scan from ptr upward with wraparound and take the first requester.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr) + i) % N;
            if (!any && req[idx]) begin
                gnt = IW'(idx);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbt_tail_tracker.sv
// Module: top of the doorbell-driven fetch scheduler.
// Decodes doorbells into per-queue tails, computes available counts, and
// raises one registered fetch request at a time chosen round robin.
// Assumes: a queue is not cleared while a request for it is raised.
module dbt_tail_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int MAX_BURST = 8,
    parameter int DEF_RING  = 16,
    localparam int QI_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [QID_W-1:0]        cfg_qid,
    input  logic [SIZE_W-1:0]       cfg_size,
    input  logic [NUM_Q-1:0]        q_clear,
    input  logic                    db_valid,
    input  logic [QID_W-1:0]        db_qid,
    input  logic [OFF_W-1:0]        db_off,
    input  logic                    db_wrap,
    output logic                    db_err,
    output logic [NUM_Q*SIZE_W-1:0] avail_o,
    output logic                    fq_valid,
    input  logic                    fq_ready,
    output logic [QID_W-1:0]        fq_qid,
    output logic [OFF_W-1:0]        fq_start,
    output logic [LEN_W-1:0]        fq_len
);
    logic [SIZE_W-1:0] q_size  [NUM_Q];
    logic [OFF_W-1:0]  q_head  [NUM_Q];
    logic [SIZE_W-1:0] q_avail [NUM_Q];
    logic [NUM_Q-1:0]  q_req;

    logic [QI_W-1:0]   db_idx, cfg_idx, gnt, rr_ptr, sel_q;
    logic              db_ok, cfg_ok, any, take;
    logic [SIZE_W-1:0] to_end, burst;
    logic [OFF_W-1:0]  sel_start;
    logic [LEN_W-1:0]  sel_len;

    // Doorbell and configuration decode with range checks.
    always_comb begin
        db_idx  = db_qid[QI_W-1:0];
        cfg_idx = cfg_qid[QI_W-1:0];
        db_ok   = db_valid && (db_qid < QID_W'(NUM_Q)) &&
                  ({1'b0, db_off} < q_size[db_idx]);
        cfg_ok  = cfg_we && (cfg_qid < QID_W'(NUM_Q));
    end

    assign take = fq_valid && fq_ready;

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_q
            dbt_queue_state #(.DEF_RING(DEF_RING), .LEN_W(LEN_W)) u_state (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (q_clear[q]),
                .cfg_we  (cfg_ok && (cfg_idx == QI_W'(q))),
                .cfg_size(cfg_size),
                .db_we   (db_ok && (db_idx == QI_W'(q))),
                .db_off  (db_off),
                .db_wrap (db_wrap),
                .adv_we  (take && (sel_q == QI_W'(q))),
                .adv_len (sel_len),
                .size_o  (q_size[q]),
                .head_o  (q_head[q]),
                .avail_o (q_avail[q])
            );
            assign q_req[q] = (q_avail[q] != '0);
            assign avail_o[q*SIZE_W +: SIZE_W] = q_avail[q];
        end
    endgenerate

    dbt_rr_arb #(.N(NUM_Q), .IW(QI_W)) u_arb (
        .req(q_req),
        .ptr(rr_ptr),
        .gnt(gnt),
        .any(any)
    );

    // Burst length: smallest of count, burst cap and slots to ring end.
    always_comb begin
        to_end = q_size[gnt] - {1'b0, q_head[gnt]};
        burst  = q_avail[gnt];
        if (burst > SIZE_W'(MAX_BURST)) burst = SIZE_W'(MAX_BURST);
        if (burst > to_end)             burst = to_end;
    end

    // Request register: load when idle, retire when taken, advance the pointer on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fq_valid  <= 1'b0;
            rr_ptr    <= '0;
            sel_q     <= '0;
            sel_start <= '0;
            sel_len   <= '0;
        end else if (take) begin
            fq_valid  <= 1'b0;
        end else if (!fq_valid && any) begin
            fq_valid  <= 1'b1;
            sel_q     <= gnt;
            sel_start <= q_head[gnt];
            sel_len   <= burst[LEN_W-1:0];
            rr_ptr    <= (gnt == QI_W'(NUM_Q - 1)) ? '0 : gnt + 1'b1;
        end
    end

    // Sticky flag for dropped doorbells.
    always_ff @(posedge clk) begin
        if (!rst_n)                   db_err <= 1'b0;
        else if (db_valid && !db_ok)  db_err <= 1'b1;
    end

    assign fq_qid   = QID_W'(sel_q);
    assign fq_start = sel_start;
    assign fq_len   = sel_len;
endmodule

// File: rtl/dbt_checker.sv
// Module: port-level properties of the fetch scheduler, bound to the top.
// Assumes: reset is synchronous active-low on the same clock.
module dbt_checker #(
    parameter int NUM_Q     = 4,
    parameter int MAX_BURST = 8,
    parameter int LEN_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             db_err,
    input logic             fq_valid,
    input logic             fq_ready,
    input logic [15:0]      fq_qid,
    input logic [14:0]      fq_start,
    input logic [LEN_W-1:0] fq_len
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid && !fq_ready |=> fq_valid && $stable(fq_qid) && $stable(fq_start) && $stable(fq_len)); // R7
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid |-> (fq_len != '0) && (int'(fq_len) <= MAX_BURST)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        db_err |=> db_err); // R5
    AST_TAKE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid && fq_ready |=> !fq_valid); // R8
    AST_QID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid |-> int'(fq_qid) < NUM_Q); // R9
endmodule

bind dbt_tail_tracker dbt_checker #(
    .NUM_Q(NUM_Q), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .db_err(db_err), .fq_valid(fq_valid),
    .fq_ready(fq_ready), .fq_qid(fq_qid), .fq_start(fq_start), .fq_len(fq_len)
);

// File: tb/tb_dbt_tail_tracker.sv
`timescale 1ns/1ps
module tb_dbt_tail_tracker;
    localparam int NQ = 4;
    localparam int LW = 4;

    typedef struct {int q; int s; int l;} fetch_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_qid = '0;
    logic [15:0]   cfg_size = '0;
    logic [NQ-1:0] q_clear = '0;
    logic          db_valid = 1'b0;
    logic [15:0]   db_qid = '0;
    logic [14:0]   db_off = '0;
    logic          db_wrap = 1'b0;
    logic          db_err;
    logic [NQ*16-1:0] avail_o;
    logic          fq_valid;
    logic          fq_ready = 1'b0;
    logic [15:0]   fq_qid;
    logic [14:0]   fq_start;
    logic [LW-1:0] fq_len;

    int checks = 0;
    int failures = 0;
    fetch_t exp_q[$];

    always #5 clk = ~clk;

    dbt_tail_tracker dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
        .cfg_size(cfg_size), .q_clear(q_clear), .db_valid(db_valid),
        .db_qid(db_qid), .db_off(db_off), .db_wrap(db_wrap), .db_err(db_err),
        .avail_o(avail_o), .fq_valid(fq_valid), .fq_ready(fq_ready),
        .fq_qid(fq_qid), .fq_start(fq_start), .fq_len(fq_len)
    );

    function automatic int av(int q);
        return int'(avail_o[q*16 +: 16]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_fetch(int q, int s, int l);
        fetch_t f;
        f.q = q; f.s = s; f.l = l;
        exp_q.push_back(f);
    endtask

    task automatic ring(int q, int off, bit w);
        @(posedge clk); #1;
        db_valid = 1'b1; db_qid = 16'(q); db_off = 15'(off); db_wrap = w;
        @(posedge clk); #1;
        db_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(int n);
        @(posedge clk); #1; fq_ready = 1'b1;
        repeat (n) @(posedge clk);
        #1; fq_ready = 1'b0;
        @(negedge clk);
        chk("R8 scoreboard empty after drain", exp_q.size(), 0);
    endtask

    // Monitor: compare every taken request against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && fq_valid && fq_ready) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected fetch qid", int'(fq_qid), -1);
            end else begin
                fetch_t e;
                e = exp_q.pop_front();
                chk("R9 fetch qid", int'(fq_qid), e.q);
                chk("R6 fetch start", int'(fq_start), e.s);
                chk("R6 fetch len", int'(fq_len), e.l);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int q15, s15, l15;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fq_valid after reset", int'(fq_valid), 0);
        chk("R1 db_err after reset", int'(db_err), 0);
        for (int q = 0; q < NQ; q++) chk("R1 avail after reset", av(q), 0);

        // Phase A: basic doorbell, repeat, hold, take.
        ring(0, 5, 1'b1);
        chk("R2 avail q0 after doorbell", av(0), 5);
        ring(0, 5, 1'b1);
        chk("R4 avail q0 after repeat", av(0), 5);
        chk("R12 fq_valid with work", int'(fq_valid), 1);
        chk("R6 start q0", int'(fq_start), 0);
        chk("R6 len q0", int'(fq_len), 5);
        q15 = int'(fq_qid); s15 = int'(fq_start); l15 = int'(fq_len);
        repeat (3) @(negedge clk);
        chk("R7 held valid", int'(fq_valid), 1);
        chk("R7 held qid", int'(fq_qid), q15);
        chk("R7 held start", int'(fq_start), s15);
        chk("R7 held len", int'(fq_len), l15);
        expect_fetch(0, 0, 5);
        drain(1);
        chk("R8 avail q0 after take", av(0), 0);
        chk("R8 fq_valid drops", int'(fq_valid), 0);

        // Phase B: size config, drops, burst cap, ring end, wrap.
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_qid = 16'd1; cfg_size = 16'd12;
        @(posedge clk); #1; cfg_we = 1'b0;
        ring(9, 3, 1'b1);
        chk("R5 err after bad qid", int'(db_err), 1);
        for (int q = 0; q < NQ; q++) chk("R5 avail unchanged by bad qid", av(q), 0);
        ring(1, 11, 1'b1);
        chk("R13 offset 11 accepted with size 12", av(1), 11);
        ring(1, 13, 1'b1);
        chk("R5 avail q1 after offset beyond size", av(1), 11);
        chk("R5 err stays set", int'(db_err), 1);
        expect_fetch(1, 0, 8);
        expect_fetch(1, 8, 3);
        drain(10);
        chk("R8 avail q1 drained", av(1), 0);
        ring(1, 4, 1'b0);
        chk("R3 avail across wrap", av(1), 5);
        expect_fetch(1, 11, 1);
        expect_fetch(1, 0, 4);
        drain(10);
        chk("R8 avail q1 after wrap drain", av(1), 0);

        // Phase C: round robin; pointer is at queue 2 after queue 1.
        ring(0, 7, 1'b1);
        ring(3, 2, 1'b1);
        ring(2, 3, 1'b1);
        expect_fetch(0, 5, 2);
        expect_fetch(2, 0, 3);   // R9: search resumes after queue 0
        expect_fetch(3, 0, 2);
        drain(12);

        // Phase D: doorbell and take on the same queue in one cycle.
        ring(0, 10, 1'b1);
        repeat (2) @(negedge clk);
        expect_fetch(0, 7, 3);
        @(posedge clk); #1;
        db_valid = 1'b1; db_qid = 16'd0; db_off = 15'd14; db_wrap = 1'b1;
        fq_ready = 1'b1;
        @(posedge clk); #1;
        db_valid = 1'b0; fq_ready = 1'b0;
        @(negedge clk);
        chk("R10 avail q0 after joint update", av(0), 4);
        expect_fetch(0, 10, 4);
        drain(4);

        // Phase E: clear while another queue's request is raised.
        ring(3, 6, 1'b1);
        ring(2, 6, 1'b1);
        chk("R2 avail q2 before clear", av(2), 3);
        @(posedge clk); #1; q_clear = 4'b0100;
        @(posedge clk); #1; q_clear = '0;
        @(negedge clk);
        chk("R11 avail q2 after clear", av(2), 0);
        ring(2, 2, 1'b1);
        chk("R11 wrap bits reinitialised to 1", av(2), 2);
        expect_fetch(3, 2, 4);
        expect_fetch(2, 0, 2);
        drain(8);

        repeat (4) @(negedge clk);
        chk("R12 no request without work", int'(fq_valid), 0);
        chk("R5 err sticky at end", int'(db_err), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule